// File: doc/BRIEF.md
# Grouped Event Selection Matrix

This block sits between the raw event sources of a cache and the counters of a performance monitor. Raw events form a grid of eight groups (columns). Each group has up to 2^CODE_W event codes (rows).

Selection happens in two levels:
- A shared 64-bit selection register picks one code per group. Each group therefore presents exactly one active event line.
- Each counter holds a small type value that names the group it follows. Two counters that name the same group always see the same event.

A per-counter origin filter then qualifies each event by the unit it came from. The block drives one registered increment pulse per counter. The counters themselves and the register access path are outside this block.

Software programs a group by writing a packed event identifier. The identifier carries the code in bits 11:4 and the group number in bits 3:0. Each write touches only that group's field. A separate clear input switches selection off as a whole without disturbing any stored field.

Top module: `event_route_matrix`

## Requirements
- R1: A selection write with identifier bits 3:0 = g (g < 8) loads identifier bits 11:4 into selection bits 8g+7:8g and sets selection bit 63 (global enable). Group 7 shares bit 63 with the enable, so only identifier bits 10:4 are stored, in bits 62:56. Group 7's effective code is that 7-bit value.
- R2: A selection write changes no other group's field. A selection write whose identifier bits 3:0 are 8 or above leaves the whole selection register unchanged.
- R3: Pulsing `sel_off` clears bit 63 and leaves every code field intact. While bit 63 is clear, no increment output is asserted.
- R4: Raw event (group g, code k) is input bit g*2^CODE_W + k of `raw_ev`. A counter whose type is g (0..7) increments when group g's selected code is active. Every counter with the same type sees the same event.
- R5: A counter whose type value is 8 or above never increments. 0xF is the reset type.
- R6: Filter word layout is {subunit accept[2:0], id-independent accept, cpu1 accept, cpu0 accept}.
  - An event from CPU n (n = 0, 1) needs filter bit n.
  - An id-independent event needs bit 2 instead; its CPU bits are ignored.
  - An event from subunit s (s = 0..2) also needs bit 3+s.
  - Subunit 3 is always rejected.
  - The origin of group g is given by `org_indep[g]`, `org_cpu[g]` and `org_sub[2g+1:2g]`.
- R7: An effective code of 0xFE is reserved for the cycle counter and is never routed. Firing that raw event produces no increment.
- R8: An increment output is registered. It rises one clock after the raw event and configuration that cause it, and is low in the same cycle.
- R9: Reset clears the selection register, sets every type to 0xF, clears every filter and drives all increments low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Selection field write strobe |
| sel_id | input | 12 | Event identifier: code in 11:4, group in 3:0 |
| sel_off | input | 1 | Clear the global selection enable |
| typ_we | input | 1 | Counter type write strobe |
| typ_idx | input | IDX_W | Counter addressed by the type write |
| typ_grp | input | 4 | Group number the counter follows |
| flt_we | input | 1 | Counter filter write strobe |
| flt_idx | input | IDX_W | Counter addressed by the filter write |
| flt_val | input | 6 | Filter accept bits |
| raw_ev | input | 8*2^CODE_W | Raw event valid bits, per group and code |
| org_indep | input | 8 | Per group: selected event is id-independent |
| org_cpu | input | 8 | Per group: originating CPU number |
| org_sub | input | 16 | Per group: 2-bit originating subunit |
| sel_q | output | 64 | Current selection register |
| inc | output | NCTR | Per-counter increment pulses |

## Verification
The assertions check these behaviours on every cycle:
- A write leaves the other groups' fields untouched, and an out-of-range group write leaves the whole register unchanged.
- No increment follows a cycle with the enable clear.
- An untyped counter stays silent.
- A counter whose group holds the reserved cycle code stays silent.

The bench's scenarios show the rest:
- That the right row of the right column reaches the counter, and that two counters sharing a column both pulse.
- Each combination of the origin filter, the group 7 narrowing, the one-cycle latency, and that reset restores the type registers.

// File: rtl/event_route_matrix.sv
module event_route_matrix #(
  parameter int NCTR   = 8,
  parameter int CODE_W = 8,
  localparam int NG    = 8,
  localparam int NCODE = 1 << CODE_W,
  localparam int IDX_W = (NCTR > 1) ? $clog2(NCTR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_we,
  input  logic [11:0]           sel_id,
  input  logic                  sel_off,
  input  logic                  typ_we,
  input  logic [IDX_W-1:0]      typ_idx,
  input  logic [3:0]            typ_grp,
  input  logic                  flt_we,
  input  logic [IDX_W-1:0]      flt_idx,
  input  logic [5:0]            flt_val,
  input  logic [NG*NCODE-1:0]   raw_ev,
  input  logic [NG-1:0]         org_indep,
  input  logic [NG-1:0]         org_cpu,
  input  logic [2*NG-1:0]       org_sub,
  output logic [63:0]           sel_q,
  output logic [NCTR-1:0]       inc
);

  localparam logic [7:0] CYC_CODE = 8'hFE;

  logic [63:0]     sel_r;
  logic [3:0]      typ_r [NCTR];
  logic [5:0]      flt_r [NCTR];
  logic [7:0]      code_g [NG];
  logic [NG-1:0]   line;
  logic [NCTR-1:0] hit;
  logic [NCTR-1:0] inc_r;

  assign sel_q = sel_r;
  assign inc   = inc_r;

  // selection register: per-field update, bit 63 is the global enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_r <= '0;
    end else begin
      if (sel_we && !sel_id[3]) begin
        if (sel_id[2:0] == 3'd7) sel_r[62:56] <= sel_id[10:4];
        else                     sel_r[{sel_id[2:0], 3'b000} +: 8] <= sel_id[11:4];
        sel_r[63] <= 1'b1;
      end
      if (sel_off) sel_r[63] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTR; i++) begin
        typ_r[i] <= 4'hF;
        flt_r[i] <= '0;
      end
    end else begin
      if (typ_we) typ_r[typ_idx] <= typ_grp;
      if (flt_we) flt_r[flt_idx] <= flt_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) inc_r <= '0;
    else        inc_r <= hit;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = 8 * g;
    localparam int FW = (g == NG - 1) ? 7 : 8;
    logic [NCODE-1:0] gev;
    assign gev = raw_ev[g*NCODE +: NCODE];

    if (g == NG - 1) begin : g_narrow
      assign code_g[g] = {1'b0, sel_r[LO +: 7]};
    end else begin : g_full
      assign code_g[g] = sel_r[LO +: 8];
    end

    if (CODE_W < 8) begin : g_short
      assign line[g] = (code_g[g][7:CODE_W] == '0) && (code_g[g] != CYC_CODE) &&
                       gev[code_g[g][CODE_W-1:0]];
    end else begin : g_wide
      assign line[g] = (code_g[g] != CYC_CODE) && gev[code_g[g]];
    end

    p_keep_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(sel_we && !sel_id[3] && sel_id[2:0] == 3'(g)) |=> $stable(sel_r[LO +: FW]));
  end

  for (genvar c = 0; c < NCTR; c++) begin : g_ctr
    logic [2:0] gs;
    logic [1:0] sub;
    logic [3:0] subm;
    logic       cpu_ok;
    logic       sub_ok;

    assign gs     = typ_r[c][2:0];
    assign sub    = org_sub[{gs, 1'b0} +: 2];
    assign subm   = {1'b0, flt_r[c][5:3]};
    assign sub_ok = subm[sub];
    assign cpu_ok = org_indep[gs] ? flt_r[c][2] : (org_cpu[gs] ? flt_r[c][1] : flt_r[c][0]);
    assign hit[c] = sel_r[63] && !typ_r[c][3] && line[gs] && cpu_ok && sub_ok;

    p_untyped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      typ_r[c][3] |=> !inc_r[c]);

    p_cycle_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!typ_r[c][3] && code_g[gs] == CYC_CODE) |=> !inc_r[c]);
  end

  p_off_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_r[63] |=> inc_r == '0);

  p_bad_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && sel_id[3] && !sel_off) |=> $stable(sel_r));

endmodule

// File: tb/tb_event_route_matrix.sv
module tb_event_route_matrix;
  localparam int CLK_PERIOD = 10;
  localparam int NCTR = 8;
  localparam int NC   = 256;

  logic clk = 1'b0;
  logic rst_n;
  logic sel_we, sel_off, typ_we, flt_we;
  logic [11:0] sel_id;
  logic [2:0] typ_idx, flt_idx;
  logic [3:0] typ_grp;
  logic [5:0] flt_val;
  logic [8*NC-1:0] raw_ev;
  logic [7:0] org_indep, org_cpu;
  logic [15:0] org_sub;
  logic [63:0] sel_q;
  logic [NCTR-1:0] inc;

  int total = 0;
  int bad = 0;
  logic [63:0] exp_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  event_route_matrix #(.NCTR(NCTR), .CODE_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_id(sel_id), .sel_off(sel_off),
    .typ_we(typ_we), .typ_idx(typ_idx), .typ_grp(typ_grp),
    .flt_we(flt_we), .flt_idx(flt_idx), .flt_val(flt_val),
    .raw_ev(raw_ev), .org_indep(org_indep), .org_cpu(org_cpu), .org_sub(org_sub),
    .sel_q(sel_q), .inc(inc));

  // {group[3:0], code[7:0], filter[5:0], fire code[7:0], indep, cpu, sub[1:0], expected}
  localparam logic [30:0] TAB [13] = '{
    {4'd1, 8'h23, 6'h3F, 8'h23, 1'b0, 1'b0, 2'd0, 1'b1},
    {4'd1, 8'h23, 6'h3F, 8'h24, 1'b0, 1'b0, 2'd0, 1'b0},
    {4'd7, 8'h7F, 6'h3F, 8'h7F, 1'b1, 1'b0, 2'd2, 1'b1},
    {4'd7, 8'hFF, 6'h3F, 8'hFF, 1'b1, 1'b0, 2'd2, 1'b0},
    {4'd0, 8'h00, 6'h3F, 8'h00, 1'b0, 1'b1, 2'd1, 1'b1},
    {4'd2, 8'h10, 6'h39, 8'h10, 1'b0, 1'b1, 2'd0, 1'b0},
    {4'd2, 8'h10, 6'h39, 8'h10, 1'b0, 1'b0, 2'd0, 1'b1},
    {4'd3, 8'h05, 6'h1F, 8'h05, 1'b0, 1'b0, 2'd2, 1'b0},
    {4'd3, 8'h05, 6'h3B, 8'h05, 1'b1, 1'b0, 2'd0, 1'b0},
    {4'd4, 8'hFE, 6'h3F, 8'hFE, 1'b0, 1'b0, 2'd0, 1'b0},
    {4'd5, 8'h80, 6'h3F, 8'h80, 1'b0, 1'b0, 2'd3, 1'b0},
    {4'd6, 8'hC4, 6'h3F, 8'hC4, 1'b1, 1'b1, 2'd1, 1'b1},
    {4'd6, 8'hC4, 6'h3C, 8'hC4, 1'b1, 1'b0, 2'd0, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_sel(input logic [11:0] id);
    if (!id[3]) begin
      if (id[2:0] == 3'd7) exp_sel[62:56] = id[10:4];
      else exp_sel[{id[2:0], 3'b000} +: 8] = id[11:4];
      exp_sel[63] = 1'b1;
    end
  endtask

  task automatic wr_sel(input logic [11:0] id);
    sel_we = 1'b1; sel_id = id;
    @(negedge clk);
    sel_we = 1'b0;
    model_sel(id);
  endtask

  task automatic wr_typ(input int idx, input logic [3:0] g);
    typ_we = 1'b1; typ_idx = 3'(idx); typ_grp = g;
    @(negedge clk);
    typ_we = 1'b0;
  endtask

  task automatic wr_flt(input int idx, input logic [5:0] v);
    flt_we = 1'b1; flt_idx = 3'(idx); flt_val = v;
    @(negedge clk);
    flt_we = 1'b0;
  endtask

  task automatic fire(input int g, input int code, input logic ind, input logic cpu,
                      input logic [1:0] sub);
    raw_ev = '0;
    raw_ev[g*NC + code] = 1'b1;
    org_indep = '0; org_cpu = '0; org_sub = '0;
    org_indep[g] = ind;
    org_cpu[g] = cpu;
    org_sub[2*g +: 2] = sub;
  endtask

  task automatic quiet();
    raw_ev = '0; org_indep = '0; org_cpu = '0; org_sub = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel_we = 0; sel_off = 0; typ_we = 0; flt_we = 0;
    sel_id = '0; typ_idx = '0; flt_idx = '0; typ_grp = '0; flt_val = '0;
    exp_sel = '0;
    quiet();
    repeat (3) @(negedge clk);
    check("R9 reset sel", sel_q, 64'h0);
    check("R9 reset inc", 64'(inc), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 13; i++) begin
      logic [30:0] e;
      e = TAB[i];
      wr_sel({e[26:19], e[30:27]});
      wr_typ(0, e[30:27]);
      wr_flt(0, e[18:13]);
      check("R1 field load", sel_q, exp_sel);
      fire(int'(e[30:27]), int'(e[12:5]), e[4], e[3], e[2:1]);
      #1;
      check("R8 no same-cycle inc", 64'(inc[0]), 64'h0);
      @(negedge clk);
      check($sformatf("R4 R6 R7 vector %0d", i), 64'(inc[0]), 64'(e[0]));
      quiet();
      @(negedge clk);
      check("R8 pulse drops", 64'(inc[0]), 64'h0);
    end

    wr_sel(12'h12A);
    check("R2 bad group ignored", sel_q, exp_sel);
    wr_sel(12'h5D2);
    check("R2 other fields kept", sel_q, exp_sel);

    wr_typ(1, 4'd1); wr_typ(2, 4'd1); wr_typ(3, 4'd2); wr_typ(5, 4'd9);
    for (int c = 1; c < 6; c++) wr_flt(c, 6'h3F);
    wr_sel(12'h231);
    fire(1, 8'h23, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    check("R4 shared group", 64'(inc[3:1]), 64'h3);
    check("R5 untyped silent", 64'({inc[5], inc[4]}), 64'h0);
    quiet();
    @(negedge clk);

    sel_off = 1'b1;
    @(negedge clk);
    sel_off = 1'b0;
    exp_sel[63] = 1'b0;
    check("R3 off keeps fields", sel_q, exp_sel);
    fire(1, 8'h23, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    check("R3 off silent", 64'(inc), 64'h0);
    quiet();
    wr_sel(12'h231);
    fire(1, 8'h23, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    check("R3 re-enabled", 64'(inc[2:1]), 64'h3);
    quiet();
    @(negedge clk);

    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears sel", sel_q, 64'h0);
    check("R9 reset clears inc", 64'(inc), 64'h0);
    rst_n = 1'b1;
    exp_sel = '0;
    wr_sel(12'h231);
    wr_flt(1, 6'h3F);
    fire(1, 8'h23, 1'b0, 1'b0, 2'd0);
    @(negedge clk);
    check("R9 type reset to unassigned", 64'(inc[1]), 64'h0);
    quiet();
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule